// File: doc/BRIEF.md
# Processor Operating-Mode Control Unit

This unit keeps the control state that decides how a processor core runs: an extended-feature model-specific register, the two control-register images that matter for mode changes (protection and paging in CR0, physical-address extension in CR4), and the long-mode bit of the current code segment. From that state it reports one of four operating modes: real, protected, compatibility or 64-bit. It also reports a long-mode-active flag.

Requests arrive on three plain request ports. The MSR port carries a 32-bit index, a read/write flag, a half select and write data. The control-register port carries a CR0/CR4 select and write data. The code-segment port loads the L bit. Every port accepts a request in any cycle and has no back-pressure. An MSR read answers exactly one cycle later on `msr_rvalid`/`msr_rdata`, and that answer cannot be stalled.

The unit checks each request against the ordering rules for entering and leaving long mode. A request that breaks a rule is dropped whole, and `err` pulses for one cycle in the next cycle. Every state change and every output takes effect one clock after the request.

Top module: `opmode_ctl`

## Requirements
- R1: After reset, `mode` is 00, `lma` is 0, `err` is 0, and every field of the extended-feature register reads 0.
- R2: The extended-feature register answers at MSR index 0xC0000080. In its low half, bit 0 (syscall enable), bit 8 (long-mode enable) and bit 11 (no-execute enable) are writable. Bit 10 reads back the long-mode-active flag and ignores writes. All other bits read 0. The high half (`msr_hi`=1) reads 0 and ignores writes. A read returns its data with `msr_rvalid`=1 one cycle after the request. A read of any other index returns 0, and a write to any other index has no effect.
- R3: An MSR request made while `ring0`=0 changes nothing, gives no read response, and pulses `err`.
- R4: A CR0 write (`cr_sel`=0) uses bit 0 as PE and bit 31 as PG; a CR4 write (`cr_sel`=1) uses bit 5 as PAE. When PG goes from 0 to 1 while long-mode enable and PAE are both 1, `lma` becomes 1.
- R5: A CR0 write that turns PG on while long-mode enable is 1 and PAE is 0 is rejected and pulses `err`.
- R6: A CR0 write that turns PG on with PE=0 in the written value is rejected and pulses `err`. When long-mode enable is 0, turning PG on with PE=1 is legal and leaves `lma` at 0.
- R7: While PG is 1, an extended-feature write that changes long-mode enable is rejected, and so is a CR4 write that changes PAE. Each pulses `err`. Writes that keep those bits unchanged are accepted.
- R8: While PG is 1, a CR0 write with PE=0 is rejected and pulses `err`, so PG must be cleared before PE. Clearing PG clears `lma`.
- R9: `cs_valid` loads `cs_lbit`. While `lma` is 1, L=1 selects 64-bit mode and L=0 selects compatibility mode. While `lma` is 0, the L bit has no effect on `mode`.
- R10: `mode` is 00 when PE=0, 01 when PE=1 and `lma`=0, 10 in compatibility mode and 11 in 64-bit mode.
- R11: Accepted requests never pulse `err`. Each rejected request pulses it for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring0 | input | 1 | Current privilege is ring 0 |
| msr_valid | input | 1 | MSR request strobe |
| msr_write | input | 1 | 1 = write, 0 = read |
| msr_hi | input | 1 | Selects the upper 32-bit half |
| msr_index | input | 32 | MSR index |
| msr_wdata | input | 32 | MSR write data for the selected half |
| msr_rvalid | output | 1 | Read response valid, one cycle after the request |
| msr_rdata | output | 32 | Read response data (0 when not valid) |
| cr_valid | input | 1 | Control-register write strobe |
| cr_sel | input | 1 | 0 = CR0, 1 = CR4 |
| cr_wdata | input | 32 | Control-register write data |
| cs_valid | input | 1 | Code-segment load strobe |
| cs_lbit | input | 1 | Long-mode bit of the loaded code segment |
| lma | output | 1 | Long mode active |
| mode | output | 2 | Operating mode encoding |
| err | output | 1 | Rejected-request pulse |

## Verification
The properties assume that the three request ports are never active in the same cycle. Under that assumption, PG and long-mode enable (or PAE) cannot both change at one edge. The stimulus holds to it by issuing exactly one request, followed by an idle cycle, before the next. The properties do not depend on what the request data looks like. For that reason the bench deliberately sends illegal orderings, foreign MSR indices and requests below ring 0.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  typedef enum logic [1:0] {
    MODE_REAL   = 2'b00,
    MODE_PROT   = 2'b01,
    MODE_COMPAT = 2'b10,
    MODE_LONG64 = 2'b11
  } opmode_e;

  // extended-feature register bit positions (low half)
  localparam int XF_SCE = 0;
  localparam int XF_LME = 8;
  localparam int XF_LMA = 10;
  localparam int XF_NXE = 11;

  // control register bit positions
  localparam int CR0_PE  = 0;
  localparam int CR0_PG  = 31;
  localparam int CR4_PAE = 5;

  localparam logic [31:0] XF_INDEX = 32'hC000_0080;

endpackage

// File: rtl/xfeat_reg.sv
module xfeat_reg
  import opmode_pkg::*;
#(
  parameter int          HALF_W = 32,
  parameter int          IDX_W  = 32,
  parameter logic [IDX_W-1:0] INDEX = IDX_W'(XF_INDEX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring0,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_hi,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [HALF_W-1:0] req_wdata,
  input  logic              pg_on,
  input  logic              lma_in,
  output logic              lme,
  output logic              rd_valid,
  output logic [HALF_W-1:0] rd_data,
  output logic              err
);

  logic sce_q, lme_q, nxe_q;
  logic hit, priv_bad, low_wr, lme_change, reject, accept;
  logic [HALF_W-1:0] low_img;

  assign hit        = (req_idx == INDEX);
  assign priv_bad   = req_valid && !ring0;
  assign low_wr     = req_valid && ring0 && hit && req_write && !req_hi;
  assign lme_change = (req_wdata[XF_LME] != lme_q);
  assign reject     = low_wr && pg_on && lme_change;
  assign accept     = low_wr && !reject;

  always_comb begin
    low_img         = '0;
    low_img[XF_SCE] = sce_q;
    low_img[XF_LME] = lme_q;
    low_img[XF_LMA] = lma_in;
    low_img[XF_NXE] = nxe_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sce_q    <= 1'b0;
      lme_q    <= 1'b0;
      nxe_q    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
    end else begin
      if (accept) begin
        sce_q <= req_wdata[XF_SCE];
        lme_q <= req_wdata[XF_LME];
        nxe_q <= req_wdata[XF_NXE];
      end
      rd_valid <= req_valid && ring0 && !req_write;
      rd_data  <= (req_valid && ring0 && !req_write && hit && !req_hi) ? low_img : '0;
      err      <= priv_bad || reject;
    end
  end

  assign lme = lme_q;

endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import opmode_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lme,
  output logic              pe,
  output logic              pg,
  output logic              pae,
  output logic              pg_next,
  output logic              err
);

  logic pe_q, pg_q, pae_q;
  logic n_pe, n_pg, n_pae;
  logic wr0, wr4, bad0, bad4;

  assign n_pe  = wr_data[CR0_PE];
  assign n_pg  = wr_data[CR0_PG];
  assign n_pae = wr_data[CR4_PAE];
  assign wr0   = wr_valid && !wr_sel;
  assign wr4   = wr_valid && wr_sel;

  // leaving: PE may not drop while paging is on
  // entering: paging needs PE, and a long-mode entry needs PAE
  assign bad0 = (pg_q && !n_pe) ||
                (!pg_q && n_pg && (!n_pe || (lme && !pae_q)));
  assign bad4 = pg_q && (n_pae != pae_q);

  assign pg_next = (wr0 && !bad0) ? n_pg : pg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_q  <= 1'b0;
      pg_q  <= 1'b0;
      pae_q <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (wr0 && !bad0) begin
        pe_q <= n_pe;
        pg_q <= n_pg;
      end
      if (wr4 && !bad4) pae_q <= n_pae;
      err <= (wr0 && bad0) || (wr4 && bad4);
    end
  end

  assign pe  = pe_q;
  assign pg  = pg_q;
  assign pae = pae_q;

endmodule

// File: rtl/mode_track.sv
module mode_track
  import opmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pe,
  input  logic       pg,
  input  logic       pg_next,
  input  logic       lme,
  input  logic       pae,
  input  logic       cs_valid,
  input  logic       cs_lbit,
  output logic       lma,
  output logic [1:0] mode
);

  logic lma_q, csl_q;
  opmode_e mode_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lma_q <= 1'b0;
      csl_q <= 1'b0;
    end else begin
      if (!pg && pg_next)  lma_q <= lme && pae;
      else if (!pg_next)   lma_q <= 1'b0;
      if (cs_valid) csl_q <= cs_lbit;
    end
  end

  always_comb begin
    if (!pe)        mode_c = MODE_REAL;
    else if (!lma_q) mode_c = MODE_PROT;
    else if (csl_q) mode_c = MODE_LONG64;
    else            mode_c = MODE_COMPAT;
  end

  assign lma  = lma_q;
  assign mode = mode_c;

endmodule

// File: rtl/opmode_ctl.sv
module opmode_ctl
  import opmode_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int IDX_W  = 32,
  parameter int CR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring0,
  input  logic              msr_valid,
  input  logic              msr_write,
  input  logic              msr_hi,
  input  logic [IDX_W-1:0]  msr_index,
  input  logic [HALF_W-1:0] msr_wdata,
  output logic              msr_rvalid,
  output logic [HALF_W-1:0] msr_rdata,
  input  logic              cr_valid,
  input  logic              cr_sel,
  input  logic [CR_W-1:0]   cr_wdata,
  input  logic              cs_valid,
  input  logic              cs_lbit,
  output logic              lma,
  output logic [1:0]        mode,
  output logic              err
);

  logic lme_w, pe_w, pg_w, pae_w, pg_nx_w, lma_w;
  logic xf_err, cr_err;

  xfeat_reg #(.HALF_W(HALF_W), .IDX_W(IDX_W)) xf_i (
    .clk(clk), .rst_n(rst_n), .ring0(ring0),
    .req_valid(msr_valid), .req_write(msr_write), .req_hi(msr_hi),
    .req_idx(msr_index), .req_wdata(msr_wdata),
    .pg_on(pg_w), .lma_in(lma_w), .lme(lme_w),
    .rd_valid(msr_rvalid), .rd_data(msr_rdata), .err(xf_err)
  );

  ctl_regs #(.DATA_W(CR_W)) cr_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(cr_valid), .wr_sel(cr_sel), .wr_data(cr_wdata),
    .lme(lme_w), .pe(pe_w), .pg(pg_w), .pae(pae_w),
    .pg_next(pg_nx_w), .err(cr_err)
  );

  mode_track mt_i (
    .clk(clk), .rst_n(rst_n),
    .pe(pe_w), .pg(pg_w), .pg_next(pg_nx_w), .lme(lme_w), .pae(pae_w),
    .cs_valid(cs_valid), .cs_lbit(cs_lbit),
    .lma(lma_w), .mode(mode)
  );

  assign lma = lma_w;
  assign err = xf_err || cr_err;

endmodule

// File: rtl/opmode_ctl_chk.sv
module opmode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ring0,
  input logic       msr_valid,
  input logic       msr_write,
  input logic       msr_rvalid,
  input logic       err,
  input logic       lma,
  input logic       pe,
  input logic       pg,
  input logic       lme,
  input logic       pae
);

  // R3
  priv_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msr_valid && !ring0 |=> err);

  // R3
  priv_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msr_valid && !ring0 |=> !msr_rvalid);

  // R2
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msr_valid && ring0 && !msr_write |=> msr_rvalid);

  // R4
  lma_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lma |-> pg && pe && lme && pae);

  // R4
  lma_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lma) |-> $rose(pg));

  // R8
  lma_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg) |-> !lma);

  // R6
  pg_needs_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg |-> pe);

  // R7
  lme_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pg) |-> $stable(lme));

  // R7
  pae_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pg) |-> $stable(pae));

endmodule

bind opmode_ctl opmode_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ring0(ring0),
  .msr_valid(msr_valid), .msr_write(msr_write), .msr_rvalid(msr_rvalid),
  .err(err), .lma(lma), .pe(pe_w), .pg(pg_w), .lme(lme_w), .pae(pae_w)
);

// File: tb/opmode_ctl_tb.sv
module opmode_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ring0 = 1'b1;
  logic        msr_valid = 1'b0, msr_write = 1'b0, msr_hi = 1'b0;
  logic [31:0] msr_index = '0, msr_wdata = '0;
  logic        msr_rvalid;
  logic [31:0] msr_rdata;
  logic        cr_valid = 1'b0, cr_sel = 1'b0;
  logic [31:0] cr_wdata = '0;
  logic        cs_valid = 1'b0, cs_lbit = 1'b0;
  logic        lma, err;
  logic [1:0]  mode;

  opmode_ctl dut_i (.*);

  always #10 clk = ~clk;

  int    n_chk = 0, n_err = 0;
  bit    done = 0, live = 0;
  string cur_tag = "R1";
  logic [31:0] last_rd;

  // reference model state
  bit m_sce, m_lme, m_nxe, m_pe, m_pg, m_pae, m_lma, m_csl;
  bit e_err, e_rv;
  logic [31:0] e_rd;
  int e_mode;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_sce, m_lme, m_nxe, m_pe, m_pg, m_pae, m_lma, m_csl} = '0;
      e_err = 0; e_rv = 0; e_rd = 0;
    end else begin
      e_err = 0; e_rv = 0; e_rd = 0;
      if (msr_valid) begin
        if (!ring0) e_err = 1;
        else if (!msr_write) begin
          e_rv = 1;
          if (msr_index == 32'hC000_0080 && !msr_hi)
            e_rd = (m_sce ? 32'h1 : 0) + (m_lme ? 32'h100 : 0) +
                   (m_lma ? 32'h400 : 0) + (m_nxe ? 32'h800 : 0);
        end else if (msr_index == 32'hC000_0080 && !msr_hi) begin
          if (m_pg && (msr_wdata[8] != m_lme)) e_err = 1;
          else begin
            m_sce = msr_wdata[0]; m_lme = msr_wdata[8]; m_nxe = msr_wdata[11];
          end
        end
      end
      if (cr_valid && !cr_sel) begin
        bit npe, npg;
        npe = cr_wdata[0]; npg = cr_wdata[31];
        if (m_pg && !npe) e_err = 1;
        else if (!m_pg && npg && (!npe || (m_lme && !m_pae))) e_err = 1;
        else begin
          if (!m_pg && npg) m_lma = m_lme && m_pae;
          if (!npg) m_lma = 0;
          m_pe = npe; m_pg = npg;
        end
      end
      if (cr_valid && cr_sel) begin
        if (m_pg && (cr_wdata[5] != m_pae)) e_err = 1;
        else m_pae = cr_wdata[5];
      end
      if (cs_valid) m_csl = cs_lbit;
    end
    e_mode = !m_pe ? 0 : (!m_lma ? 1 : (m_csl ? 3 : 2));
  end

  // per-cycle comparison against the model (R10, R11 and the active tag)
  always @(negedge clk) begin
    if (live) begin
      chk(cur_tag, "mode R10", {30'b0, mode}, e_mode);
      chk(cur_tag, "lma", {31'b0, lma}, {31'b0, m_lma});
      chk(cur_tag, "err R11", {31'b0, err}, {31'b0, e_err});
      chk(cur_tag, "rvalid", {31'b0, msr_rvalid}, {31'b0, e_rv});
      chk(cur_tag, "rdata", msr_rdata, e_rd);
    end
  end

  task automatic msr(input bit wr, input bit hi, input logic [31:0] idx,
                     input logic [31:0] d);
    @(negedge clk);
    msr_valid = 1; msr_write = wr; msr_hi = hi; msr_index = idx; msr_wdata = d;
    @(negedge clk);
    last_rd = msr_rdata;
    msr_valid = 0;
  endtask

  task automatic crw(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cr_valid = 1; cr_sel = sel; cr_wdata = d;
    @(negedge clk);
    cr_valid = 0;
  endtask

  task automatic csl(input bit l);
    @(negedge clk);
    cs_valid = 1; cs_lbit = l;
    @(negedge clk);
    cs_valid = 0;
  endtask

  localparam logic [31:0] XF = 32'hC000_0080;
  localparam logic [31:0] PE = 32'h1, PGPE = 32'h8000_0001, PGONLY = 32'h8000_0000;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    @(negedge clk);
    // R1
    chk("R1", "mode", {30'b0, mode}, 0);
    chk("R1", "lma", {31'b0, lma}, 0);
    chk("R1", "err", {31'b0, err}, 0);
    msr(0, 0, XF, 0);
    chk("R1", "efer", last_rd, 0);

    // R2 field layout
    cur_tag = "R2";
    msr(1, 0, XF, 32'hFFFF_FFFF);
    msr(0, 0, XF, 0);
    chk("R2", "efer low", last_rd, 32'h0000_0901);
    msr(1, 1, XF, 32'hFFFF_FFFF);
    msr(0, 1, XF, 0);
    chk("R2", "efer high", last_rd, 0);
    msr(1, 0, 32'h0000_0010, 32'h0);
    msr(0, 0, 32'h0000_0010, 0);
    chk("R2", "foreign idx", last_rd, 0);
    msr(1, 0, XF, 32'h0);

    // R3 below ring 0
    cur_tag = "R3";
    ring0 = 0;
    msr(1, 0, XF, 32'h100);
    ring0 = 1;
    msr(0, 0, XF, 0);
    chk("R3", "efer unchanged", last_rd, 0);

    // R6 paging without protection
    cur_tag = "R6";
    crw(0, PGONLY);
    chk("R6", "mode", {30'b0, mode}, 0);

    // R5 long-mode entry without PAE
    cur_tag = "R5";
    msr(1, 0, XF, 32'h100);
    crw(0, PGPE);
    chk("R5", "lma", {31'b0, lma}, 0);
    chk("R5", "mode", {30'b0, mode}, 0);

    // R4 proper entry order
    cur_tag = "R4";
    crw(1, 32'h20);
    crw(0, PE);
    chk("R4", "mode prot", {30'b0, mode}, 1);
    crw(0, PGPE);
    chk("R4", "lma", {31'b0, lma}, 1);
    chk("R4", "mode compat", {30'b0, mode}, 2);
    msr(0, 0, XF, 0);
    chk("R4", "efer lma", last_rd, 32'h0000_0500);

    // R9 code-segment L bit
    cur_tag = "R9";
    csl(1);
    chk("R9", "mode 64", {30'b0, mode}, 3);
    csl(0);
    chk("R9", "mode compat", {30'b0, mode}, 2);
    csl(1);

    // R7 frozen enables while paging
    cur_tag = "R7";
    msr(1, 0, XF, 32'h0);
    crw(1, 32'h0);
    msr(1, 0, XF, 32'h900);
    msr(0, 0, XF, 0);
    chk("R7", "efer", last_rd, 32'h0000_0D00);

    // R8 leaving order
    cur_tag = "R8";
    crw(0, 32'h0);
    chk("R8", "mode kept", {30'b0, mode}, 3);
    crw(0, PE);
    chk("R8", "lma", {31'b0, lma}, 0);
    chk("R8", "mode prot", {30'b0, mode}, 1);
    crw(0, 32'h0);
    chk("R8", "mode real", {30'b0, mode}, 0);

    // R6 legacy paging, R9 L bit ignored
    cur_tag = "R6";
    msr(1, 0, XF, 32'h0);
    crw(0, PGPE);
    chk("R6", "lma", {31'b0, lma}, 0);
    chk("R6", "mode", {30'b0, mode}, 1);
    cur_tag = "R9";
    csl(1);
    chk("R9", "mode ignores L", {30'b0, mode}, 1);
    crw(0, PE);
    crw(0, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule